// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that gives an external host read and write access to a small register file: 32 entries of 8 bits each. The host opens an access by pulling the active-low select line low. It then clocks in a command byte and exchanges one data byte with the block. The command byte holds a direction flag, a 5-bit register address and two spare bits that the block ignores.

For a write, the block captures the data byte from the serial input and stores it when the sixteenth bit arrives. For a read, the block shifts the addressed register out on the serial output, least significant bit first. The output is qualified by an output-enable flag, which stands for a high-impedance driver.

The three host lines are asynchronous to the system clock. They pass through a two-stage synchronizer, and the serial clock edges are then detected in the system clock domain. The interface carries one byte per framed access and has no flow control. It is a plain control port, so it has no valid/ready handshake and no back-pressure. The host sets the pace through the serial clock.

Top module: `serial_regport`

## Requirements
- R1: After reset every register reads 0x00, the serial output enable is low and the serial output is low.
- R2: The first bit of a frame is the direction flag: 1 means read and 0 means write. The next five bits are the register address, least significant bit first. Bits 6 and 7 are spare bits, and their values have no effect on the access.
- R3: In a write frame, bits 8 to 15 form the data byte, least significant bit first. The byte is stored into the addressed register on the rising serial clock edge that carries bit 15.
- R4: In a read frame, the addressed register is driven on the serial output, least significant bit first. Each bit changes only after a falling serial clock edge. Data bit 0 appears after the falling edge that follows the eighth rising edge, and each bit stays stable through the following rising edge.
- R5: The output enable is low while select is high, during the command byte, and for the whole of a write frame. It is high during the data phase of a read frame.
- R6: If select returns high before the sixteenth rising edge, the access is abandoned and no register changes.
- R7: The bit counter returns to zero while select is high. Rising edges after the sixteenth in one frame are ignored and do not alter the stored byte.
- R8: All three host inputs are synchronized into the system clock domain. The port works correctly whenever each serial clock phase lasts at least six system clock cycles.
- R9: A read frame leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host; data is sampled on its rising edge |
| sdin_i | input | 1 | Serial data from the host |
| sdout_o | output | 1 | Serial read data to the host |
| sdout_en_o | output | 1 | High when the serial output is driven; low means high impedance |

## Verification
The hardest situations to reach from the ports are frames that break off early or run past sixteen bits. The bench drives both through a transfer task that takes an explicit bit count: one abort falls inside the command byte, one inside the data byte, and one frame carries eight extra bits. Each of these frames is followed by a normal read whose expected byte comes from a model that the early or surplus bits never update. The edge on which read data changes is checked by sampling the output both just before and just after each rising serial clock edge. A frame with the minimum phase length tests the margin left by the synchronizer.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int SPARE_W = 2;
  localparam int CMD_BITS = 1 + ADDR_W + SPARE_W;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int DEPTH = 32,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> (!$stable(addr_i) || $stable(rdata_o)));
endmodule

// File: rtl/srp_core.sv
module srp_core
  import serial_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_act_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdin_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdout_o,
  output logic              sdout_en_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] DSTART = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] ALAST = CNT_W'(ADDR_W);

  logic [CNT_W-1:0]  cnt_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wbuf_q;
  logic [DATA_W-1:0] rsh_q;
  logic              sdo_q, oe_q;
  logic              in_data, take_bit;

  assign take_bit = sel_act_i && rise_i && (cnt_q < FULL);
  assign in_data  = (cnt_q >= DSTART) && (cnt_q < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      wbuf_q <= '0;
      rsh_q  <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!sel_act_i) begin
      cnt_q <= '0;
      rd_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (take_bit) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0) rd_q <= sdin_i;
        else if (cnt_q <= ALAST) addr_q <= {sdin_i, addr_q[ADDR_W-1:1]};
        else if (cnt_q >= DSTART) wbuf_q <= {sdin_i, wbuf_q[DATA_W-1:1]};
      end
      if (fall_i && rd_q && in_data) begin
        oe_q <= 1'b1;
        if (cnt_q == DSTART) begin
          sdo_q <= rdata_i[0];
          rsh_q <= rdata_i >> 1;
        end else begin
          sdo_q <= rsh_q[0];
          rsh_q <= rsh_q >> 1;
        end
      end
    end
  end

  assign addr_o     = addr_q;
  assign wr_en_o    = take_bit && (cnt_q == LAST) && !rd_q;
  assign wr_data_o  = {sdin_i, wbuf_q[DATA_W-1:1]};
  assign sdout_o    = sdo_q;
  assign sdout_en_o = oe_q;

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act_i |=> !sdout_en_o);
  // R5
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdout_en_o |-> rd_q);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act_i |=> (cnt_q == '0));
  // R3
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (sel_act_i && !rd_q && rise_i));
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import serial_regport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_i,
  input  logic sclk_i,
  input  logic sdin_i,
  output logic sdout_o,
  output logic sdout_en_o
);
  logic [2:0]        sync_q;
  logic              sck_d_q;
  logic              rise, fall;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rdata;

  srp_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sel_n_i, sclk_i, sdin_i}),
    .q_o(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d_q <= 1'b0;
    else        sck_d_q <= sync_q[1];
  end

  assign rise = sync_q[1] && !sck_d_q;
  assign fall = !sync_q[1] && sck_d_q;

  srp_core i_core (
    .clk(clk), .rst_n(rst_n),
    .sel_act_i(!sync_q[2]),
    .rise_i(rise), .fall_i(fall),
    .sdin_i(sync_q[0]),
    .rdata_i(rdata),
    .addr_o(addr),
    .wr_en_o(wr_en),
    .wr_data_o(wr_data),
    .sdout_o(sdout_o),
    .sdout_en_o(sdout_en_o)
  );

  srp_regfile #(.DEPTH(1 << ADDR_W), .DW(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_en),
    .addr_i(addr),
    .wdata_i(wr_data),
    .rdata_o(rdata)
  );
endmodule

// File: tb/test_serial_regport.sv
module test_serial_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_en;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  logic [7:0] model [32];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_q [$];

  always #4 clk = ~clk;

  serial_regport i_serial_regport (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk),
    .sdin_i(sdin), .sdout_o(sdout), .sdout_en_o(sdout_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [4:0] a, input logic [1:0] sp,
                      input logic [15:0] dat, input int nb, input int h,
                      output logic [7:0] got);
    logic [23:0] vec;
    vec = {dat, sp, a, rd};
    got = '0;
    sel_n = 1'b0;
    repeat (h) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdin = vec[i];
      repeat (h) @(negedge clk);
      if (i == 3) chk("R5 enable low in command byte", {7'd0, sdout_en}, 8'd0);
      if (i == 10) chk("R5 enable in data phase", {7'd0, sdout_en}, {7'd0, rd});
      if (rd && i >= 8 && i < 16) got[i-8] = sdout;
      sclk = 1'b1;
      repeat (h) @(negedge clk);
      if (rd && i >= 8 && i < 16 && sdout !== got[i-8])
        chk("R4 output stable across rising edge", {7'd0, sdout}, {7'd0, got[i-8]});
      sclk = 1'b0;
    end
    repeat (h) @(negedge clk);
    sel_n = 1'b1;
    repeat (h + 3) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [1:0] sp);
    logic [7:0] g;
    xfer(1'b0, a, sp, {8'h00, d}, 16, 8, g);
    model[a] = d;
    chk("R5 enable low after write frame", {7'd0, sdout_en}, 8'd0);
  endtask

  task automatic rd(input logic [4:0] a, input logic [1:0] sp, input int h, input string tag);
    logic [7:0] g;
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
    xfer(1'b1, a, sp, 16'h0000, 16, h, g);
    got_q.push_back(g);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (got_q.size() > 0) chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [7:0] g;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 enable low after reset", {7'd0, sdout_en}, 8'd0);
    chk("R1 output low after reset", {7'd0, sdout}, 8'd0);
    rd(5'd0, 2'b00, 8, "R1 register zero after reset");
    rd(5'd31, 2'b00, 8, "R1 top register zero after reset");
    wr(5'd3, 8'hA5, 2'b00);
    rd(5'd3, 2'b00, 8, "R3 R4 write then read");
    wr(5'd0, 8'h01, 2'b00);
    wr(5'd31, 8'h80, 2'b00);
    wr(5'd16, 8'h3C, 2'b00);
    rd(5'd0, 2'b00, 8, "R2 address 0");
    rd(5'd31, 2'b00, 8, "R2 address 31");
    rd(5'd16, 2'b00, 8, "R2 address 16");
    wr(5'd9, 8'h96, 2'b11);
    rd(5'd9, 2'b10, 8, "R2 spare bits ignored");
    rd(5'd3, 2'b00, 8, "R2 spare bits did not redirect write");
    // R6 abort inside the data byte, then inside the command byte
    xfer(1'b0, 5'd3, 2'b00, 16'h00FF, 12, 8, g);
    rd(5'd3, 2'b00, 8, "R6 abort in data byte");
    xfer(1'b0, 5'd3, 2'b00, 16'h0000, 4, 8, g);
    rd(5'd3, 2'b00, 8, "R6 abort in command byte");
    // R7 surplus bits after the sixteenth
    xfer(1'b0, 5'd7, 2'b00, 16'hFF5A, 24, 8, g);
    model[7] = 8'h5A;
    rd(5'd7, 2'b00, 8, "R7 surplus bits ignored");
    // R9 repeated reads leave contents unchanged
    rd(5'd16, 2'b00, 8, "R9 first read");
    rd(5'd16, 2'b00, 8, "R9 second read unchanged");
    // R8 minimum phase length
    rd(5'd31, 2'b00, 6, "R8 read at minimum phase length");
    xfer(1'b0, 5'd12, 2'b00, 16'h00C3, 16, 6, g);
    model[12] = 8'hC3;
    rd(5'd12, 2'b00, 8, "R8 write at minimum phase length");
    chk("R5 enable low with select high", {7'd0, sdout_en}, 8'd0);
    repeat (4) @(negedge clk);
    chk("scoreboard drained", 8'(got_q.size()), 8'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule